// File: doc/BRIEF.md
# Masked Broadcast Load Unit

This block takes one memory beat holding up to eight 32-bit elements and spreads a scalar, or a repeating group of 2, 4 or 8 elements, over a 16-lane vector of 32-bit lanes. A per-lane write mask decides which lanes take the broadcast value. Each lane whose mask bit is clear either keeps its old destination value or is cleared to zero, as chosen by an input.

Alongside the data path, the block drives one read enable per beat element. An element is requested from memory only when at least one enabled lane will consume it. A lane consumes the group element whose index equals the lane number modulo the group length. A request with an empty mask therefore reads nothing, and a memory fault on an unread element can be suppressed element by element.

The read enables follow the request combinationally. The result vector is registered and appears with a valid strobe one cycle after the request.

Top module: `vec_bcast_unit`

## Requirements
- R1: With `tuple_sel` = 0 (group length 1), every lane whose mask bit is set receives beat element 0, which is bits 31:0 of `mem_beat`.
- R2: When `req_valid` is high and `lane_mask` is all zero, every bit of `elem_rd_en` is low.
- R3: With `tuple_sel` = s, the group length is T = 2^s (1, 2, 4 or 8). A lane i with its mask bit set receives beat element i mod T. Element e occupies bits 32e+31:32e of `mem_beat`, and lane i occupies bits 32i+31:32i of `res_vec` and `old_dst`.
- R4: During a request, `elem_rd_en[e]` is high exactly when e < T and at least one of the mask bits e, e+T, e+2T, ... is set. Bits at e >= T stay low.
- R5: With `zero_fill` = 0, a lane whose mask bit is clear takes its value from `old_dst`.
- R6: With `zero_fill` = 1, a lane whose mask bit is clear is zero.
- R7: `res_valid` is high in exactly the cycle after each cycle with `req_valid` high. `res_vec` holds its value when no request is made.
- R8: During reset (active-high, synchronous), `res_valid` and `res_vec` are cleared to zero.
- R9: While `req_valid` is low, `elem_rd_en` is all zero, whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| tuple_sel | input | 2 | log2 of the group length (0..3 gives 1, 2, 4, 8) |
| lane_mask | input | 16 | Per-lane write mask |
| zero_fill | input | 1 | 1: clear masked-off lanes; 0: keep old values |
| mem_beat | input | 256 | Memory beat, eight 32-bit elements |
| old_dst | input | 512 | Previous destination vector |
| elem_rd_en | output | 8 | Per-element memory read enables |
| res_valid | output | 1 | Result valid strobe |
| res_vec | output | 512 | Result vector |

## Verification
The hardest case is a lone mask bit in the upper half of the vector that has to raise a high group element. An example is lane 15 under a group of 8, which must select element 7 and no other. A bit that aliases onto element 0 only under the larger groups is just as hard. The stimulus places single mask bits and sparse strided patterns in lanes 8 to 15 for every group length, and checks the enables in the same cycle. Back-to-back requests with varied masks, followed by idle cycles, exercise the one-cycle result timing and the hold behaviour.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

    localparam int unsigned LANES_DEF     = 16;
    localparam int unsigned ELEM_W_DEF    = 32;
    localparam int unsigned MAX_GROUP_DEF = 8;
    localparam int unsigned GSEL_W        = 2;

    typedef enum logic [GSEL_W-1:0] {
        GRP_1 = 2'd0,
        GRP_2 = 2'd1,
        GRP_4 = 2'd2,
        GRP_8 = 2'd3
    } group_e;

    typedef struct packed {
        logic   zero_fill;
        group_e group;
    } bcast_ctl_t;

    function automatic int unsigned group_len(input group_e g);
        return 32'd1 << g;
    endfunction

endpackage

// File: rtl/vbc_read_enable.sv
module vbc_read_enable
    import vbc_pkg::*;
#(
    parameter int unsigned LANES     = LANES_DEF,
    parameter int unsigned MAX_GROUP = MAX_GROUP_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  group_e               group,
    input  logic [LANES-1:0]     lane_mask,
    output logic [MAX_GROUP-1:0] rd_en
);
    localparam int unsigned EW = (MAX_GROUP > 1) ? $clog2(MAX_GROUP) : 1;

    logic [EW-1:0] idx_mask;

    always_comb begin
        idx_mask = EW'(group_len(group) - 1);
    end

    // A lane feeds the element its low index bits select; OR all consumers.
    always_comb begin
        rd_en = '0;
        for (int i = 0; i < LANES; i++) begin
            if (req_valid && lane_mask[i]) begin
                rd_en[EW'(i) & idx_mask] = 1'b1;
            end
        end
    end

    // R4
    rd_en_range_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(rd_en) >> group_len(group)) == 32'd0);

endmodule

// File: rtl/vbc_lane_mux.sv
module vbc_lane_mux
    import vbc_pkg::*;
#(
    parameter int unsigned LANES     = LANES_DEF,
    parameter int unsigned ELEM_W    = ELEM_W_DEF,
    parameter int unsigned MAX_GROUP = MAX_GROUP_DEF
) (
    input  bcast_ctl_t                  ctl,
    input  logic [LANES-1:0]            lane_mask,
    input  logic [MAX_GROUP*ELEM_W-1:0] mem_beat,
    input  logic [LANES*ELEM_W-1:0]     old_dst,
    output logic [LANES*ELEM_W-1:0]     lane_vec
);
    localparam int unsigned EW = (MAX_GROUP > 1) ? $clog2(MAX_GROUP) : 1;

    logic [EW-1:0] idx_mask;

    always_comb begin
        idx_mask = EW'(group_len(ctl.group) - 1);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [EW-1:0]     sel;
        logic [ELEM_W-1:0] bval;
        always_comb begin
            sel  = EW'(i) & idx_mask;
            bval = mem_beat[sel*ELEM_W +: ELEM_W];
            if (lane_mask[i]) begin
                lane_vec[i*ELEM_W +: ELEM_W] = bval;
            end else if (ctl.zero_fill) begin
                lane_vec[i*ELEM_W +: ELEM_W] = '0;
            end else begin
                lane_vec[i*ELEM_W +: ELEM_W] = old_dst[i*ELEM_W +: ELEM_W];
            end
        end
    end

endmodule

// File: rtl/vec_bcast_unit.sv
module vec_bcast_unit
    import vbc_pkg::*;
#(
    parameter int unsigned LANES     = LANES_DEF,
    parameter int unsigned ELEM_W    = ELEM_W_DEF,
    parameter int unsigned MAX_GROUP = MAX_GROUP_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [GSEL_W-1:0]           tuple_sel,
    input  logic [LANES-1:0]            lane_mask,
    input  logic                        zero_fill,
    input  logic [MAX_GROUP*ELEM_W-1:0] mem_beat,
    input  logic [LANES*ELEM_W-1:0]     old_dst,
    output logic [MAX_GROUP-1:0]        elem_rd_en,
    output logic                        res_valid,
    output logic [LANES*ELEM_W-1:0]     res_vec
);
    localparam int unsigned VEC_W = LANES * ELEM_W;

    bcast_ctl_t       ctl;
    logic [VEC_W-1:0] lane_vec;

    always_comb begin
        ctl.zero_fill = zero_fill;
        ctl.group     = group_e'(tuple_sel);
    end

    vbc_read_enable #(
        .LANES     (LANES),
        .MAX_GROUP (MAX_GROUP)
    ) u_rden (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .group     (ctl.group),
        .lane_mask (lane_mask),
        .rd_en     (elem_rd_en)
    );

    vbc_lane_mux #(
        .LANES     (LANES),
        .ELEM_W    (ELEM_W),
        .MAX_GROUP (MAX_GROUP)
    ) u_mux (
        .ctl       (ctl),
        .lane_mask (lane_mask),
        .mem_beat  (mem_beat),
        .old_dst   (old_dst),
        .lane_vec  (lane_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_vec   <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_vec <= lane_vec;
            end
        end
    end

    // R7
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(res_vec));

    // R2
    empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && lane_mask == '0) |-> elem_rd_en == '0);

    // R9
    no_req_read_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> elem_rd_en == '0);

    // R6
    zero_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && zero_fill && lane_mask == '0) |=> res_vec == '0);

    // R5
    merge_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !zero_fill && lane_mask == '0) |=> res_vec == $past(old_dst));

    // R1
    scalar_full_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && tuple_sel == '0 && lane_mask == '1)
        |=> res_vec == {LANES{$past(mem_beat[ELEM_W-1:0])}});

endmodule

// File: tb/test_vec_bcast_unit.sv
module test_vec_bcast_unit;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [1:0]   tuple_sel = '0;
    logic [15:0]  lane_mask = '0;
    logic         zero_fill = 1'b0;
    logic [255:0] mem_beat = '0;
    logic [511:0] old_dst = '0;
    logic [7:0]   elem_rd_en;
    logic         res_valid;
    logic [511:0] res_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [511:0] exp_q[$];
    string        tag_q[$];
    logic [511:0] last_exp = '0;

    always #5 clk = ~clk;

    vec_bcast_unit i_vec_bcast_unit (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .tuple_sel  (tuple_sel),
        .lane_mask  (lane_mask),
        .zero_fill  (zero_fill),
        .mem_beat   (mem_beat),
        .old_dst    (old_dst),
        .elem_rd_en (elem_rd_en),
        .res_valid  (res_valid),
        .res_vec    (res_vec)
    );

    function automatic logic [7:0] m_rd(int t, logic [15:0] m);
        logic [7:0] r = '0;
        for (int i = 0; i < 16; i++) if (m[i]) r[i % t] = 1'b1;
        return r;
    endfunction

    function automatic logic [511:0] m_vec(int t, logic [15:0] m, logic z,
                                           logic [255:0] b, logic [511:0] o);
        logic [511:0] v;
        for (int i = 0; i < 16; i++) begin
            if (m[i])  v[i*32 +: 32] = b[(i % t)*32 +: 32];
            else if (z) v[i*32 +: 32] = 32'd0;
            else        v[i*32 +: 32] = o[i*32 +: 32];
        end
        return v;
    endfunction

    function automatic logic [255:0] mk_beat(int seed);
        logic [255:0] b;
        for (int e = 0; e < 8; e++) b[e*32 +: 32] = 32'hA000_0000 + 32'(e * 17 + seed * 4099);
        return b;
    endfunction

    function automatic logic [511:0] mk_old(int seed);
        logic [511:0] o;
        for (int i = 0; i < 16; i++) o[i*32 +: 32] = 32'h5000_0000 + 32'(i * 257 + seed * 65537);
        return o;
    endfunction

    task automatic send(input logic [1:0] ts, input logic [15:0] m, input logic z,
                        input int seed, input string tag);
        int t;
        logic [7:0] er;
        t = 1 << ts;
        @(negedge clk);
        req_valid = 1'b1;
        tuple_sel = ts;
        lane_mask = m;
        zero_fill = z;
        mem_beat  = mk_beat(seed);
        old_dst   = mk_old(seed);
        #1;
        er = m_rd(t, m);
        checks++;
        if (elem_rd_en !== er) begin
            fails++;
            $display("FAIL %s read enables: actual=%b expected=%b", tag, elem_rd_en, er);
        end
        exp_q.push_back(m_vec(t, m, z, mem_beat, old_dst));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare each produced result with the scoreboard head.
    always @(negedge clk) begin
        if (!rst && !done && res_valid) begin
            logic [511:0] e;
            string tg;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R7 unexpected result: actual=%h expected=none", res_vec);
            end else begin
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                last_exp = e;
                if (res_vec !== e) begin
                    fails++;
                    $display("FAIL %s result: actual=%h expected=%h", tg, res_vec, e);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_vec !== '0) begin
            fails++;
            $display("FAIL R8 reset: actual=%b/%h expected=0/0", res_valid, res_vec);
        end
        rst = 1'b0;

        // R9: mask present but no request
        @(negedge clk);
        lane_mask = 16'hFFFF;
        #1;
        checks++;
        if (elem_rd_en !== 8'h00) begin
            fails++;
            $display("FAIL R9 idle reads: actual=%b expected=00000000", elem_rd_en);
        end

        send(2'd0, 16'hFFFF, 1'b0, 1, "R1");
        send(2'd0, 16'h0000, 1'b0, 2, "R2");
        send(2'd3, 16'h0000, 1'b1, 3, "R2");
        send(2'd1, 16'hFFFF, 1'b0, 4, "R3");
        send(2'd2, 16'hFFFF, 1'b1, 5, "R3");
        send(2'd3, 16'hFFFF, 1'b0, 6, "R3");
        send(2'd2, 16'h0100, 1'b0, 7, "R4");
        send(2'd3, 16'h8000, 1'b1, 8, "R4");
        send(2'd3, 16'h4400, 1'b0, 9, "R4");
        send(2'd1, 16'h0800, 1'b1, 10, "R4");
        send(2'd2, 16'h3C00, 1'b0, 11, "R4");
        send(2'd0, 16'hA5A5, 1'b0, 12, "R5");
        send(2'd2, 16'h0F0F, 1'b0, 13, "R5");
        send(2'd0, 16'h5A5A, 1'b1, 14, "R6");
        send(2'd3, 16'hF00F, 1'b1, 15, "R6");
        idle();
        send(2'd1, 16'h1234, 1'b0, 16, "R7");
        idle();
        idle();
        for (int k = 0; k < 24; k++) begin
            send(2'(k % 4), 16'((k * 40503 + 7) ^ (k << 9)), 1'(k % 3 == 0), 20 + k, "R3");
        end
        idle();
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_vec !== last_exp) begin
            fails++;
            $display("FAIL R7 hold: actual=%b/%h expected=0/%h", res_valid, res_vec, last_exp);
        end
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R7 missing results: actual=%0d pending expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule